// File: doc/BRIEF.md
# Chip-Select Decoder With Error Response

This block sits between an internal bus master and an external multiplexed address/data bus. Each incoming transfer is decoded against six chip-select windows. Every window has a base address, an ignore mask, an enable bit, a write-lock bit and a data-lane placement bit. When exactly one enabled window claims the address and the access is permitted, the block drives that window's chip-select low and raises a cycle-start strobe. Otherwise it answers the internal master with a bus error, and no external activity follows.

The decode result comes back one clock after the request, over a plain valid-style handshake. The full 32-bit transfer address is registered onto the external address output for every granted cycle. A placement flag tells the data phase whether the granted device's data sits at the top of the 32-bit bus or starts at bit 0. Window settings are static inputs, supplied by whatever logic owns the configuration.

Top module: `csdec_top`

## Requirements
- R1: When the address of a request matches exactly one enabled window and the access is allowed, in the next cycle rspValid=1, rspErr=0, cycleStart=1, and csN has only bit i low, where i is the index of the matching window.
- R2: When the address of a request matches no enabled window, in the next cycle rspValid=1, rspErr=1, cycleStart=0 and every bit of csN is high.
- R3: When the address of a request matches two or more enabled windows, in the next cycle rspValid=1, rspErr=1, cycleStart=0 and every bit of csN is high.
- R4: A write (reqWrite=1) whose single matching window has winWrProt set gets rspErr=1, cycleStart=0 and every csN bit high.
- R5: A read (reqWrite=0) whose single matching window has winWrProt set is granted in the normal way, as in R1.
- R6: Window i matches when ((reqAddr XOR winBase[i]) AND NOT winMask[i]) is zero. A mask bit of 1 excludes that address bit from the comparison.
- R7: A window whose winValid bit is 0 never matches, whatever its base and mask are.
- R8: On every granted cycle, extAddr carries all 32 bits of the request address in the response cycle. A refused request leaves extAddr unchanged.
- R9: On a granted cycle, dataFromBit0 takes the winLaneLow bit of the granted window. 1 means data starts at bus bit 0; 0 means data is packed from bit 31 downward. A refused request leaves dataFromBit0 unchanged.
- R10: rspValid is high in exactly the cycle after each cycle with reqValid=1. In a cycle that follows no request, rspValid, rspErr and cycleStart are low and csN is all ones.
- R11: While rstN is low, rspValid, rspErr and cycleStart are low, csN is all ones and extAddr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer request, one cycle per transfer |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Transfer address |
| winBase | input | 6x32 | Base address of each window |
| winMask | input | 6x32 | Per-window ignore mask, 1 = bit not compared |
| winValid | input | 6 | Window enable |
| winWrProt | input | 6 | Window refuses writes |
| winLaneLow | input | 6 | Data placement of each window, 1 = from bit 0 |
| rspValid | output | 1 | Decode result present |
| rspErr | output | 1 | Transfer refused with bus error |
| cycleStart | output | 1 | External cycle begins |
| csN | output | 6 | Active-low one-hot chip-selects |
| extAddr | output | 32 | Address driven on the external bus |
| dataFromBit0 | output | 1 | Data placement of the granted window |

## Verification
Every decode result is registered once, so rspValid, rspErr, cycleStart, csN, extAddr and dataFromBit0 all change at the first rising edge after the request cycle. The bench drives the request at a falling edge, waits one rising edge, and samples at the following falling edge. It then drops the request and checks the cycle after that for the idle pattern of R10. Back-to-back requests are sampled in the same way, one response per cycle. The held values of extAddr and dataFromBit0 after a refusal are checked against the last granted request.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  // Strobes from control to datapath for one decode slot
  typedef struct packed {
    logic respond;   // a request was seen, produce a result
    logic grant;     // launch an external cycle
    logic fault;     // refuse with bus error
  } dpStrobes_t;

  typedef enum logic [2:0] {
    DC_IDLE,
    DC_GRANT,
    DC_MISS,
    DC_MULTI,
    DC_WPROT
  } decodeClass_t;

endpackage

// File: rtl/csdec_window_match.sv
module csdec_window_match #(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] winBase,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] winMask,
  input  logic [NUM_WIN-1:0]             winValid,
  output logic [NUM_WIN-1:0]             hitVec
);

  // One comparator per window; mask bit 1 removes that bit from the compare
  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    logic [ADDR_W-1:0] careBits;
    logic [ADDR_W-1:0] diffBits;
    assign careBits  = ~winMask[i];
    assign diffBits  = (addr ^ winBase[i]) & careBits;
    assign hitVec[i] = winValid[i] && (diffBits == '0);
  end

endmodule

// File: rtl/csdec_ctrl.sv
module csdec_ctrl
  import csdec_pkg::*;
#(
  parameter int NUM_WIN = 6
) (
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [NUM_WIN-1:0] hitVec,
  input  logic [NUM_WIN-1:0] winWrProt,
  output dpStrobes_t         strb
);

  localparam int CNT_W = $clog2(NUM_WIN + 1);

  decodeClass_t decClass;
  logic [CNT_W-1:0] hitCount;
  logic wpHit;

  always_comb begin
    hitCount = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      hitCount = hitCount + CNT_W'(hitVec[i]);
    end
  end

  assign wpHit = |(hitVec & winWrProt);

  always_comb begin
    if (!reqValid)                 decClass = DC_IDLE;
    else if (hitCount == '0)       decClass = DC_MISS;
    else if (hitCount > CNT_W'(1)) decClass = DC_MULTI;
    else if (reqWrite && wpHit)    decClass = DC_WPROT;
    else                           decClass = DC_GRANT;
  end

  always_comb begin
    strb.respond = (decClass != DC_IDLE);
    strb.grant   = (decClass == DC_GRANT);
    strb.fault   = (decClass == DC_MISS) || (decClass == DC_MULTI) ||
                   (decClass == DC_WPROT);
  end

endmodule

// File: rtl/csdec_datapath.sv
module csdec_datapath
  import csdec_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] winBase,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] winMask,
  input  logic [NUM_WIN-1:0]             winValid,
  input  logic [NUM_WIN-1:0]             winLaneLow,
  input  dpStrobes_t                     strb,
  output logic [NUM_WIN-1:0]             hitVec,
  output logic                           rspValid,
  output logic                           rspErr,
  output logic                           cycleStart,
  output logic [NUM_WIN-1:0]             csN,
  output logic [ADDR_W-1:0]              extAddr,
  output logic                           dataFromBit0
);

  logic laneSel;

  csdec_window_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) uMatch (
    .addr     (reqAddr),
    .winBase  (winBase),
    .winMask  (winMask),
    .winValid (winValid),
    .hitVec   (hitVec)
  );

  assign laneSel = |(hitVec & winLaneLow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspErr       <= 1'b0;
      cycleStart   <= 1'b0;
      csN          <= '1;
      extAddr      <= '0;
      dataFromBit0 <= 1'b0;
    end else begin
      rspValid   <= strb.respond;
      rspErr     <= strb.fault;
      cycleStart <= strb.grant;
      csN        <= strb.grant ? ~hitVec : '1;
      if (strb.grant) begin
        extAddr      <= reqAddr;
        dataFromBit0 <= laneSel;
      end
    end
  end

endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic                           reqWrite,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] winBase,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] winMask,
  input  logic [NUM_WIN-1:0]             winValid,
  input  logic [NUM_WIN-1:0]             winWrProt,
  input  logic [NUM_WIN-1:0]             winLaneLow,
  output logic                           rspValid,
  output logic                           rspErr,
  output logic                           cycleStart,
  output logic [NUM_WIN-1:0]             csN,
  output logic [ADDR_W-1:0]              extAddr,
  output logic                           dataFromBit0
);

  dpStrobes_t strb;
  logic [NUM_WIN-1:0] hitVec;

  csdec_ctrl #(.NUM_WIN(NUM_WIN)) uCtrl (
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .hitVec    (hitVec),
    .winWrProt (winWrProt),
    .strb      (strb)
  );

  csdec_datapath #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .reqAddr      (reqAddr),
    .winBase      (winBase),
    .winMask      (winMask),
    .winValid     (winValid),
    .winLaneLow   (winLaneLow),
    .strb         (strb),
    .hitVec       (hitVec),
    .rspValid     (rspValid),
    .rspErr       (rspErr),
    .cycleStart   (cycleStart),
    .csN          (csN),
    .extAddr      (extAddr),
    .dataFromBit0 (dataFromBit0)
  );

endmodule

// File: rtl/csdec_checks.sv
module csdec_checks #(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqWrite,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic [NUM_WIN-1:0] winWrProt,
  input logic               rspValid,
  input logic               rspErr,
  input logic               cycleStart,
  input logic [NUM_WIN-1:0] csN,
  input logic [ADDR_W-1:0]  extAddr
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN) reqValid |=> rspValid); // R10
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN) !reqValid |=> (!rspValid && !cycleStart && !rspErr)); // R10
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(~csN)); // R1
  AST_START_ONE_CS: assert property (@(posedge clk) disable iff (!rstN) cycleStart |-> ($countones(~csN) == 1 && rspValid && !rspErr)); // R1
  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rstN) rspErr |-> (&csN && !cycleStart && rspValid)); // R2
  AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) (cycleStart && $past(reqWrite)) |-> ((~csN & $past(winWrProt)) == '0)); // R4
  AST_ADDR_FULL: assert property (@(posedge clk) disable iff (!rstN) cycleStart |-> (extAddr == $past(reqAddr))); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN) (rspValid && !cycleStart) |-> $stable(extAddr)); // R8

endmodule

bind csdec_top csdec_checks #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) uChecks (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqAddr    (reqAddr),
  .winWrProt  (winWrProt),
  .rspValid   (rspValid),
  .rspErr     (rspErr),
  .cycleStart (cycleStart),
  .csN        (csN),
  .extAddr    (extAddr)
);

// File: tb/sim_csdec_top.sv
module sim_csdec_top;

  localparam int NW = 6;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqWrite;
  logic [31:0] reqAddr;
  logic [NW-1:0][31:0] winBase, winMask;
  logic [NW-1:0] winValid, winWrProt, winLaneLow;
  logic rspValid, rspErr, cycleStart, dataFromBit0;
  logic [NW-1:0] csN;
  logic [31:0] extAddr;

  int checks = 0;
  int fails = 0;
  logic [31:0] lastAddr = '0;
  logic lastLane = 1'b0;

  always #5 clk = ~clk;

  csdec_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .winBase(winBase), .winMask(winMask),
    .winValid(winValid), .winWrProt(winWrProt), .winLaneLow(winLaneLow),
    .rspValid(rspValid), .rspErr(rspErr), .cycleStart(cycleStart),
    .csN(csN), .extAddr(extAddr), .dataFromBit0(dataFromBit0)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected result from the decode rules of R1-style grant, miss, overlap, lock
  task automatic model(input logic [31:0] a, input logic w,
                       output logic [NW-1:0] expCsN, output logic expErr,
                       output logic expLane);
    int hits = 0;
    int idx = 0;
    for (int i = 0; i < NW; i++) begin
      if (winValid[i] && (((a ^ winBase[i]) & ~winMask[i]) == 32'h0)) begin
        hits++;
        idx = i;
      end
    end
    expCsN = '1;
    expErr = 1'b1;
    expLane = lastLane;
    if (hits == 1 && !(w && winWrProt[idx])) begin
      expCsN[idx] = 1'b0;
      expErr = 1'b0;
      expLane = winLaneLow[idx];
    end
  endtask

  // Called at a falling edge; result sampled at the next falling edge
  task automatic issue(input logic [31:0] a, input logic w, input string req);
    logic [NW-1:0] eCs;
    logic eErr, eLane;
    model(a, w, eCs, eErr, eLane);
    reqValid = 1'b1;
    reqAddr  = a;
    reqWrite = w;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (!eErr) begin
      lastAddr = a;
      lastLane = eLane;
    end
    check({req, " rspValid R10"}, 64'(rspValid), 64'(1));
    check({req, " rspErr"}, 64'(rspErr), 64'(eErr));
    check({req, " cycleStart"}, 64'(cycleStart), 64'(!eErr));
    check({req, " csN"}, 64'(csN), 64'(eCs));
    check({req, " extAddr R8"}, 64'(extAddr), 64'(lastAddr));
    check({req, " dataFromBit0 R9"}, 64'(dataFromBit0), 64'(eLane));
  endtask

  task automatic idleCheck();
    @(posedge clk);
    @(negedge clk);
    check("R10 idle rspValid", 64'(rspValid), 64'(0));
    check("R10 idle csN", 64'(csN), 64'({NW{1'b1}}));
    check("R10 idle cycleStart", 64'(cycleStart), 64'(0));
    check("R10 idle rspErr", 64'(rspErr), 64'(0));
  endtask

  task automatic testSingleHit();
    issue(32'h0001_2340, 1'b0, "R1 single read w0");
    check("R1 csN w0", 64'(csN), 64'(6'b111110));
    idleCheck();
    issue(32'h2010_0000, 1'b1, "R1 single write w2");
    check("R9 lane w2", 64'(dataFromBit0), 64'(1));
    idleCheck();
  endtask

  task automatic testMiss();
    issue(32'h9000_0000, 1'b0, "R2 miss");
    check("R2 err", 64'(rspErr), 64'(1));
    check("R8 addr held", 64'(extAddr), 64'(32'h2010_0000));
    idleCheck();
  endtask

  task automatic testOverlap();
    issue(32'h2080_0010, 1'b0, "R3 overlap");
    check("R3 err", 64'(rspErr), 64'(1));
    check("R3 no cs", 64'(csN), 64'(6'b111111));
    idleCheck();
  endtask

  task automatic testWriteLock();
    issue(32'h1000_0004, 1'b1, "R4 locked write");
    check("R4 err", 64'(rspErr), 64'(1));
    issue(32'h1000_0004, 1'b0, "R5 locked read");
    check("R5 csN w1", 64'(csN), 64'(6'b111101));
    check("R9 lane w1", 64'(dataFromBit0), 64'(1));
    idleCheck();
  endtask

  task automatic testMaskEdges();
    issue(32'h5000_1234, 1'b0, "R6 exact hit w5");
    check("R6 csN w5", 64'(csN), 64'(6'b011111));
    check("R9 lane w5", 64'(dataFromBit0), 64'(0));
    issue(32'h5000_1235, 1'b0, "R6 off by one");
    check("R6 off by one err", 64'(rspErr), 64'(1));
    issue(32'h000F_FFFF, 1'b0, "R6 top of w0");
    check("R6 top of w0", 64'(csN), 64'(6'b111110));
    issue(32'h0010_0000, 1'b0, "R6 past w0");
    check("R6 past w0 err", 64'(rspErr), 64'(1));
    idleCheck();
  endtask

  task automatic testDisabled();
    issue(32'h3000_0010, 1'b0, "R7 disabled window");
    check("R7 err", 64'(rspErr), 64'(1));
    @(negedge clk);
    winValid[4] = 1'b1;
    issue(32'h3000_0010, 1'b0, "R7 enabled window");
    check("R7 csN w4", 64'(csN), 64'(6'b101111));
    idleCheck();
  endtask

  initial begin
    rstN = 1'b0;
    reqValid = 1'b0;
    reqWrite = 1'b0;
    reqAddr = '0;
    winBase[0] = 32'h0000_0000; winMask[0] = 32'h000F_FFFF;
    winBase[1] = 32'h1000_0000; winMask[1] = 32'h0000_FFFF;
    winBase[2] = 32'h2000_0000; winMask[2] = 32'h00FF_FFFF;
    winBase[3] = 32'h2080_0000; winMask[3] = 32'h000F_FFFF;
    winBase[4] = 32'h3000_0000; winMask[4] = 32'h0000_0FFF;
    winBase[5] = 32'h5000_1234; winMask[5] = 32'h0000_0000;
    winValid   = 6'b101111;
    winWrProt  = 6'b000010;
    winLaneLow = 6'b010110;
    repeat (3) @(negedge clk);
    check("R11 reset rspValid", 64'(rspValid), 64'(0));
    check("R11 reset rspErr", 64'(rspErr), 64'(0));
    check("R11 reset cycleStart", 64'(cycleStart), 64'(0));
    check("R11 reset csN", 64'(csN), 64'(6'b111111));
    check("R11 reset extAddr", 64'(extAddr), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    testSingleHit();
    testMiss();
    testOverlap();
    testWriteLock();
    testMaskEdges();
    testDisabled();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule